// File: doc/BRIEF.md
# Full-Duplex Serial Port with Four Framing Modes

This block is the serial channel of an 8-bit microcontroller core. It has its own transmit and receive buffers, so one frame can go out while another comes in. A single data address serves both buffers: a write loads the transmit side and starts a frame, and the value read back is always the last byte received. A control register selects one of four modes and holds the enables, the ninth-bit values and the two completion flags. Software clears those flags.

Mode 0 is a synchronous shifter that sends eight bits at one twelfth of the system clock and drives a shift clock. Mode 1 sends 10-bit asynchronous frames. Modes 2 and 3 send 11-bit frames that carry a ninth data bit. The bit rate of modes 1 and 3 comes from the overflow pulse of an external timer. Mode 2 runs at a fixed fraction of the system clock. A rate-double input halves the bit period in the asynchronous modes. The transmit and receive pins belong to this block alone and are not shared with any port pins.

Top module: `ser51_port`

## Requirements
- R1: After reset, txd_o and shift_clk_o are 1, ctl_o is 0x00 and rx_data_o is 0x00.
- R2: In mode 1 (ctl bits [7:6]=01), a byte written through tx_wr_i is sent on txd_o LSB first. The frame is a 0 start bit, eight data bits and a 1 stop bit. Transmission begins on the cycle after the write. Each bit lasts 16 sample ticks. A sample tick is every second t1_ovf_i pulse when baud_dbl_i=0, and every pulse when baud_dbl_i=1.
- R3: Modes 2 (10) and 3 (11) send the start bit, eight data bits, then ctl bit 3, then the stop bit. In mode 3 the sample ticks are those of R2. In mode 2 a free-running 2-bit counter starts from 0 at reset and advances every clock. A tick occurs when it reads 3, or when its low bit is 1 if baud_dbl_i=1.
- R4: Mode 0 (00) sends eight bits LSB first on txd_o, 12 clocks per bit. During each bit, shift_clk_o is 0 for the first 6 clocks and 1 for the last 6. Outside a transfer it is 1.
- R5: The transmit flag (ctl bit 1) is set on the cycle the stop bit starts (modes 1 to 3), or on the cycle after the last mode 0 bit ends. It stays set until a control write puts 0 in that bit. A hardware set in the same cycle wins over the write.
- R6: A tx_wr_i strobe while a frame is in progress is ignored, and the frame continues unchanged.
- R7: In modes 1 to 3 with ctl bit 4 set, the receiver starts on a 1-to-0 change of the synchronized rxd_i seen at a sample tick. It takes each bit as the 2-of-3 majority of the samples at ticks 7, 8 and 9 after start detection. On completion it loads rx_data_o. In modes 2 and 3 ctl bit 2 gets the ninth bit, and in mode 1 it gets the stop bit. Ctl bit 0 is then set.
- R8: A start bit whose majority value is 1 is rejected. No flag is set and the receiver waits for the next falling edge.
- R9: With ctl bit 4 clear, or in mode 0, nothing is received: ctl bit 0 and rx_data_o keep their values.
- R10: A frame that completes while ctl bit 0 is set is discarded, and rx_data_o keeps the older byte.
- R11: Transmission and reception run at the same time: a frame looped from txd_o back to rxd_i is received while it is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control write data: [7:6] mode, [4] rx enable, [3] tx ninth bit, [2] rx ninth bit, [1] tx flag, [0] rx flag |
| ctl_o | output | 8 | Control register contents, bit 5 reads 0 |
| tx_wr_i | input | 1 | Data write strobe, starts a frame |
| tx_data_i | input | 8 | Byte to send |
| rx_data_o | output | 8 | Last byte received |
| baud_dbl_i | input | 1 | Rate-double select |
| t1_ovf_i | input | 1 | Timer overflow pulse, one clock wide |
| rxd_i | input | 1 | Serial input |
| txd_o | output | 1 | Serial output |
| shift_clk_o | output | 1 | Mode 0 shift clock |

## Verification
The hardest cases to reach are the receiver's rejection paths: a start bit that turns out to be a glitch, and a frame that ends while the previous byte is still unclaimed. The bench disconnects the loopback and drives a low pulse of only two sample ticks. It then reconnects txd_o to rxd_i and shows that the detector has rearmed by receiving a full frame. For the overrun case, it leaves the receive flag set and sends a second looped frame. A behavioural model that tracks timer ticks, the free-running prescaler and a queue of frame bits predicts txd_o, shift_clk_o and the transmit flag on every clock.

// File: rtl/ser51_pkg.sv
package ser51_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT = 2'd0,
    MODE_UART8 = 2'd1,
    MODE_FIX9  = 2'd2,
    MODE_TMR9  = 2'd3
  } ser_mode_e;

  localparam int unsigned DATA_W    = 8;
  localparam int unsigned SUB_W     = 4;   // 16x oversampling
  localparam int unsigned SHIFT_DIV = 12;  // mode 0 clocks per bit
  localparam int unsigned PRE_W     = 2;   // mode 2 prescaler
endpackage

// File: rtl/ser51_baud.sv
module ser51_baud
  import ser51_pkg::*;
#(
  parameter int unsigned PW = PRE_W
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  ser_mode_e mode_i,
  input  logic      dbl_i,
  input  logic      ovf_i,
  output logic      tick_o
);
  logic [PW-1:0] pre_q;
  logic          half_q;
  logic          tick_fix, tick_tmr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      half_q <= 1'b0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (ovf_i) half_q <= ~half_q;
    end
  end

  assign tick_fix = dbl_i ? (&pre_q[PW-2:0]) : (&pre_q);
  assign tick_tmr = ovf_i & (dbl_i | half_q);
  assign tick_o   = (mode_i == MODE_FIX9) ? tick_fix : tick_tmr;
endmodule

// File: rtl/ser51_tx.sv
module ser51_tx
  import ser51_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned SW  = SUB_W,
  parameter int unsigned DIV = SHIFT_DIV
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ser_mode_e     mode_i,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  input  logic          bit9_i,
  output logic          txd_o,
  output logic          sclk_o,
  output logic          flag_set_o
);
  localparam int unsigned FW = DW + 3;
  localparam int unsigned CW = $clog2(FW + 1);

  logic          busy_q;
  logic [FW-1:0] sr_q;
  logic [CW-1:0] left_q;
  logic [SW-1:0] sub_q, lim;
  ser_mode_e     mode_q;
  logic          base, step, shift_m;

  assign shift_m    = (mode_q == MODE_SHIFT);
  assign base       = shift_m | tick_i;
  assign lim        = shift_m ? SW'(DIV - 1) : '1;
  assign step       = busy_q & base & (sub_q == lim);
  assign flag_set_o = step & (shift_m ? (left_q == CW'(1)) : (left_q == CW'(2)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sr_q   <= '1;
      left_q <= '0;
      sub_q  <= '0;
      mode_q <= MODE_SHIFT;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        sub_q  <= '0;
        mode_q <= mode_i;
        unique case (mode_i)
          MODE_SHIFT: begin sr_q <= {3'b111, data_i};               left_q <= CW'(DW);     end
          MODE_UART8: begin sr_q <= {2'b11, data_i, 1'b0};          left_q <= CW'(DW + 2); end
          default:    begin sr_q <= {1'b1, bit9_i, data_i, 1'b0};   left_q <= CW'(DW + 3); end
        endcase
      end
    end else if (base) begin
      if (sub_q == lim) begin
        sub_q  <= '0;
        sr_q   <= {1'b1, sr_q[FW-1:1]};
        left_q <= left_q - 1'b1;
        if (left_q == CW'(1)) busy_q <= 1'b0;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign txd_o  = busy_q ? sr_q[0] : 1'b1;
  assign sclk_o = (busy_q & shift_m) ? (sub_q >= SW'(DIV / 2)) : 1'b1;

  // R6
  wr_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i && !base |=> $stable(sr_q));
  // R2
  sub_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !base |=> $stable(sub_q));
endmodule

// File: rtl/ser51_rx.sv
module ser51_rx
  import ser51_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned SW = SUB_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ser_mode_e     mode_i,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          rxd_i,
  output logic          load_o,
  output logic [DW-1:0] data_o,
  output logic          bit9_o
);
  localparam int unsigned OVS = 1 << SW;
  localparam int unsigned MID = OVS / 2 + 1;
  localparam int unsigned IW  = $clog2(DW + 3);

  logic [1:0]    sync_q, vote_q;
  logic          prev_q, busy_q, rx, maj, fire, false_start, shift_en;
  logic [SW-1:0] sub_q, sub_n;
  logic [IW-1:0] idx_q, last;
  logic [DW:0]   sh_q, sh_n, word;
  ser_mode_e     mode_q;

  assign rx          = sync_q[1];
  assign sub_n       = sub_q + 1'b1;
  assign maj         = (vote_q[0] & vote_q[1]) | (vote_q[0] & rx) | (vote_q[1] & rx);
  assign last        = (mode_q == MODE_UART8) ? IW'(DW + 1) : IW'(DW + 2);
  assign fire        = busy_q & tick_i & (sub_n == SW'(MID));
  assign false_start = fire & (idx_q == '0) & maj;
  assign shift_en    = (idx_q != '0) & (idx_q <= IW'(DW + 1));
  assign sh_n        = {maj, sh_q[DW:1]};
  assign word        = shift_en ? sh_n : sh_q;
  assign load_o      = fire & (idx_q == last);
  assign data_o      = word[DW-1:0];
  assign bit9_o      = word[DW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
      busy_q <= 1'b0;
      sub_q  <= '0;
      idx_q  <= '0;
      vote_q <= '0;
      sh_q   <= '0;
      mode_q <= MODE_SHIFT;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      if (tick_i) prev_q <= rx;
      if (!busy_q) begin
        if (tick_i && prev_q && !rx && en_i && mode_i != MODE_SHIFT) begin
          busy_q <= 1'b1;
          sub_q  <= '0;
          idx_q  <= '0;
          mode_q <= mode_i;
        end
      end else if (tick_i) begin
        sub_q <= sub_n;
        if (sub_n == SW'(MID - 2)) vote_q[0] <= rx;
        if (sub_n == SW'(MID - 1)) vote_q[1] <= rx;
        if (fire) begin
          idx_q <= idx_q + 1'b1;
          if (shift_en) sh_q <= sh_n;
          if (false_start || load_o) busy_q <= 1'b0;
        end
      end
    end
  end

  // R8
  false_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    false_start |=> !busy_q);
  // R7
  rx_sub_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !tick_i |=> $stable(sub_q));
endmodule

// File: rtl/ser51_port.sv
module ser51_port
  import ser51_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_wr_i,
  input  logic [7:0] ctl_wdata_i,
  output logic [7:0] ctl_o,
  input  logic       tx_wr_i,
  input  logic [7:0] tx_data_i,
  output logic [7:0] rx_data_o,
  input  logic       baud_dbl_i,
  input  logic       t1_ovf_i,
  input  logic       rxd_i,
  output logic       txd_o,
  output logic       shift_clk_o
);
  ser_mode_e         mode_q;
  logic              ren_q, tb8_q, rb8_q, ti_q, ri_q;
  logic [DATA_W-1:0] rbuf_q, rx_word;
  logic              tick, ti_set, rx_load, rx_bit9;
  logic              unused_spare;

  assign unused_spare = ctl_wdata_i[5];

  ser51_baud u_baud (
    .clk_i, .rst_ni, .mode_i(mode_q), .dbl_i(baud_dbl_i), .ovf_i(t1_ovf_i), .tick_o(tick)
  );

  ser51_tx u_tx (
    .clk_i, .rst_ni, .mode_i(mode_q), .tick_i(tick), .start_i(tx_wr_i),
    .data_i(tx_data_i), .bit9_i(tb8_q), .txd_o, .sclk_o(shift_clk_o), .flag_set_o(ti_set)
  );

  ser51_rx u_rx (
    .clk_i, .rst_ni, .mode_i(mode_q), .en_i(ren_q), .tick_i(tick), .rxd_i,
    .load_o(rx_load), .data_o(rx_word), .bit9_o(rx_bit9)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SHIFT;
      {ren_q, tb8_q, rb8_q, ti_q, ri_q} <= '0;
      rbuf_q <= '0;
    end else begin
      if (ctl_wr_i) begin
        mode_q <= ser_mode_e'(ctl_wdata_i[7:6]);
        {ren_q, tb8_q, rb8_q, ti_q, ri_q} <= ctl_wdata_i[4:0];
      end
      if (ti_set) ti_q <= 1'b1;
      if (rx_load && !ri_q) begin
        rbuf_q <= rx_word;
        rb8_q  <= rx_bit9;
        ri_q   <= 1'b1;
      end
    end
  end

  assign ctl_o     = {mode_q, 1'b0, ren_q, tb8_q, rb8_q, ti_q, ri_q};
  assign rx_data_o = rbuf_q;

  // R5
  tx_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ti_set |=> ti_q);
  // R10
  overrun_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_load && ri_q |=> $stable(rbuf_q));
endmodule

// File: tb/ser51_port_tb.sv
module ser51_port_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ctl_wr = 1'b0, tx_wr = 1'b0, dbl = 1'b0, t1_ovf = 1'b0;
  logic [7:0] ctl_wdata = '0, tx_data = '0;
  logic       rxd_drv = 1'b1, loop_en = 1'b0;
  logic [7:0] ctl, rx_data;
  logic       txd, sclk, rxd;
  int         errors = 0, checks = 0, ovf_per = 0, ovf_cnt = 0;
  bit         done = 1'b0;

  assign rxd = loop_en ? txd : rxd_drv;
  always #(CLK_PERIOD / 2) clk = ~clk;

  ser51_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata), .ctl_o(ctl),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data), .rx_data_o(rx_data), .baud_dbl_i(dbl),
    .t1_ovf_i(t1_ovf), .rxd_i(rxd), .txd_o(txd), .shift_clk_o(sclk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // timer overflow pulse generator
  always @(negedge clk) begin
    if (ovf_per > 0) begin
      ovf_cnt++;
      if (ovf_cnt >= ovf_per) begin t1_ovf = 1'b1; ovf_cnt = 0; end
      else t1_ovf = 1'b0;
    end else t1_ovf = 1'b0;
  end

  // behavioural reference for the transmit side
  bit       m_fr[$];
  bit       m_busy, m_half, m_ti, m_tick, m_set, m_base;
  int       m_q, m_sub, m_tm, m_lim;
  bit [7:0] m_ctl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fr.delete(); m_busy = 0; m_half = 0; m_ti = 0; m_q = 0; m_sub = 0; m_tm = 0; m_ctl = 0;
    end else begin
      if (m_ctl[7:6] == 2)
        m_tick = dbl ? (m_q % 2 == 1) : (m_q % 4 == 3);
      else
        m_tick = t1_ovf && (dbl || m_half);
      m_set = 0;
      if (m_busy) begin
        m_base = (m_tm == 0) || m_tick;
        m_lim  = (m_tm == 0) ? 11 : 15;
        if (m_base) begin
          if (m_sub == m_lim) begin
            m_sub = 0;
            if ((m_tm == 0 && m_fr.size() == 1) || (m_tm != 0 && m_fr.size() == 2)) m_set = 1;
            void'(m_fr.pop_front());
            if (m_fr.size() == 0) m_busy = 0;
          end else m_sub++;
        end
      end else if (tx_wr) begin
        m_tm = m_ctl[7:6]; m_sub = 0; m_busy = 1;
        if (m_tm != 0) m_fr.push_back(1'b0);
        for (int i = 0; i < 8; i++) m_fr.push_back(tx_data[i]);
        if (m_tm >= 2) m_fr.push_back(m_ctl[3]);
        if (m_tm != 0) m_fr.push_back(1'b1);
      end
      if (ctl_wr) begin m_ctl = ctl_wdata & 8'hDF; m_ti = ctl_wdata[1]; end
      if (m_set) m_ti = 1;
      if (t1_ovf) m_half = ~m_half;
      m_q = (m_q + 1) % 4;
    end
  end

  // per-cycle comparison of transmit pins and flag (R2/R3/R4/R5/R6)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(txd == (m_busy ? m_fr[0] : 1'b1), "R2/R3/R6 txd", txd, m_busy ? m_fr[0] : 1'b1);
      check(sclk == ((m_busy && m_tm == 0) ? (m_sub >= 6) : 1'b1), "R4 shift clock", sclk,
            (m_busy && m_tm == 0) ? (m_sub >= 6) : 1'b1);
      check(ctl[1] == m_ti, "R5 tx flag", ctl[1], m_ti);
      check({ctl[7:6], ctl[4:3]} == {m_ctl[7:6], m_ctl[4:3]}, "R1 ctl fields",
            {ctl[7:6], ctl[4:3]}, {m_ctl[7:6], m_ctl[4:3]});
    end
  end

  task automatic ctl_write(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); tx_wr = 1'b1; tx_data = b;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic wait_tx();
    for (int i = 0; i < 20000 && m_busy; i++) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic loop_frame(input logic [7:0] b, input logic [7:0] exp_d, input bit exp_b9,
                            input string req);
    loop_en = 1'b1;
    send(b);
    wait_tx();
    check(rx_data == exp_d, req, rx_data, exp_d);
    check(ctl[2] == exp_b9, req, ctl[2], exp_b9);
    check(ctl[0] == 1'b1, req, ctl[0], 1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(txd == 1'b1, "R1 txd", txd, 1);
    check(sclk == 1'b1, "R1 sclk", sclk, 1);
    check(ctl == 8'h00, "R1 ctl", ctl, 0);
    check(rx_data == 8'h00, "R1 rx_data", rx_data, 0);
    rst_n = 1'b1;
    ovf_per = 3;

    // R2 + R11: mode 1, loopback, slow rate; R6: write during frame
    ctl_write(8'h50);
    loop_en = 1'b1;
    send(8'hA5);
    repeat (200) @(negedge clk);
    send(8'hFF);
    wait_tx();
    check(rx_data == 8'hA5, "R6/R11 rx", rx_data, 8'hA5);
    check(ctl[2] == 1'b1, "R7 stop bit in rb8", ctl[2], 1);
    check(ctl[0] == 1'b1, "R7 rx flag", ctl[0], 1);

    // R10 overrun: rx flag left set
    send(8'h3C);
    wait_tx();
    check(rx_data == 8'hA5, "R10 overrun keeps byte", rx_data, 8'hA5);

    // R2 doubled rate
    dbl = 1'b1;
    ctl_write(8'h50);
    loop_frame(8'h3C, 8'h3C, 1'b1, "R2 doubled");

    // R3 mode 2, both rates, ninth bit set and clear
    dbl = 1'b0;
    ctl_write(8'h98);
    loop_frame(8'h5A, 8'h5A, 1'b1, "R3 mode2 tb8=1");
    dbl = 1'b1;
    ctl_write(8'h90);
    loop_frame(8'hE1, 8'hE1, 1'b0, "R3 mode2 tb8=0");

    // R3 mode 3 on timer ticks
    dbl = 1'b0; ovf_per = 2;
    ctl_write(8'hD8);
    loop_frame(8'hC3, 8'hC3, 1'b1, "R3 mode3");

    // R4 + R9: mode 0 with rx enabled, looped back; receiver stays idle
    ctl_write(8'h10);
    loop_en = 1'b1;
    send(8'h96);
    wait_tx();
    check(ctl[0] == 1'b0, "R9 mode0 no rx", ctl[0], 0);
    check(rx_data == 8'hC3, "R9 mode0 rx_data", rx_data, 8'hC3);
    check(ctl[1] == 1'b1, "R5 mode0 tx flag", ctl[1], 1);

    // R9: receiver disabled in mode 1
    ctl_write(8'h40);
    send(8'h12);
    wait_tx();
    check(ctl[0] == 1'b0, "R9 ren=0 flag", ctl[0], 0);
    check(rx_data == 8'hC3, "R9 ren=0 data", rx_data, 8'hC3);

    // R8: false start of two ticks, then a real frame to show rearm
    ovf_per = 3;
    ctl_write(8'h50);
    loop_en = 1'b0;
    @(negedge clk); rxd_drv = 1'b0;
    repeat (12) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (400) @(negedge clk);
    check(ctl[0] == 1'b0, "R8 false start", ctl[0], 0);
    check(rx_data == 8'hC3, "R8 data kept", rx_data, 8'hC3);
    loop_frame(8'h81, 8'h81, 1'b1, "R8 rearm");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule